// File: doc/BRIEF.md
# Stepped Startup Drive Sequencer

This block times the removal of extra amplifier current from a crystal oscillator during startup. The oscillator core has five switched current legs that add to the base bias and raise the negative resistance the crystal sees. A strong drive gets the oscillation growing quickly. Left on, the same drive would push the crystal past its rated power. The sequencer starts with every leg switched on. It counts cycles of the squared-up oscillator clock itself. After a fixed interval it switches the legs off one at a time, with the same interval between steps. The drive therefore falls in equal steps rather than dropping all at once.

The clock input is the oscillator's own output, so the sequencer only advances while the oscillation is running. A power-on reset, asynchronous and active low, restores full drive. When the last leg goes off, a done flag marks low-power steady operation. An external controller can also cut all remaining legs at once through an override input.

States:
- `ST_BOOST`: all legs are on and the first interval is being counted.
- `ST_TAPER`: at least one leg is off and the legs are being removed.
- `ST_STEADY`: every leg is off and done is set.

Transitions:
- BOOST to TAPER when the interval expires and more than one leg remains.
- BOOST or TAPER to STEADY when the interval expires with one leg left, or when the override is sampled high.
- STEADY holds until reset.

Top module: `xo_boost_seq`

## Requirements
- R1: While `por_n` is low, `leg_en` is 5'b11111 and `steady_done` is 0. This holds immediately, without waiting for a clock edge.
- R2: Outputs change only on rising `clk_osc` edges. Bit 0 of `leg_en` goes low on the INTERVAL-th (default 28th) rising edge after `por_n` goes high.
- R3: Each further leg goes low exactly INTERVAL edges after the previous one, that is on edges 2·INTERVAL through 5·INTERVAL.
- R4: Legs turn off from bit 0 up to bit 4. `leg_en` always reads 11111, 11110, 11100, 11000, 10000 or 00000, so the enables form a thermometer code with no gap.
- R5: Without the override, no edge turns off more than one leg.
- R6: `steady_done` rises on the same edge that turns the last leg (bit 4) off.
- R7: Once `steady_done` is high, `leg_en` stays 0 and `steady_done` stays 1 until reset. No leg ever turns back on without reset.
- R8: If `force_lp` is high at a rising edge before done, that edge clears all of `leg_en` and sets `steady_done`.
- R9: `force_lp` has no effect while reset is held. It also has no effect once done is already set.
- R10: Asserting reset in the middle of the sequence restores all legs at once. After release, the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Squared oscillator clock; rising edges are counted |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| force_lp | input | 1 | Override: drop all remaining legs at the next edge |
| leg_en | output | 5 | Active-high enable per boost leg, bit 0 removed first |
| steady_done | output | 1 | High once all legs are off (low-power steady mode) |

## Verification
The hardest case to reach is the timing of a reset that lands in the middle of the taper. The bench releases reset partway through a clock period and aborts a run after two legs have dropped. It then checks at once that all legs are back on, and that the next run again waits the full interval before the first drop. The override is exercised in three places: on the very first edge, partway through the taper, and held through reset and after done. The last two are the cases where it must change nothing.

// File: rtl/xob_pkg.sv
package xob_pkg;
    typedef enum logic [1:0] {
        ST_BOOST  = 2'd0,
        ST_TAPER  = 2'd1,
        ST_STEADY = 2'd2
    } xob_state_e;
endpackage

// File: rtl/xob_interval_timer.sv
module xob_interval_timer #(
    parameter int INTERVAL = 28,
    parameter int CW       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: the interval count never passes its terminal value
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/xob_leg_bank.sv
module xob_leg_bank #(
    parameter int NUM_LEGS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                kill,
    output logic [NUM_LEGS-1:0] en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '1;
        end else if (kill) begin
            en <= '0;
        end else if (step) begin
            en <= {en[NUM_LEGS-2:0], 1'b0};
        end
    end

    // R4: disabled legs occupy a contiguous run from bit 0
    assert_thermo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((~en) & ((~en) + 1'b1)) == '0));

    // R7: a leg that is off never comes back without reset
    assert_no_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en & ~$past(en)) == '0));
endmodule

// File: rtl/xo_boost_seq.sv
module xo_boost_seq
    import xob_pkg::*;
#(
    parameter int NUM_LEGS = 5,
    parameter int INTERVAL = 28
) (
    input  logic                clk_osc,
    input  logic                por_n,
    input  logic                force_lp,
    output logic [NUM_LEGS-1:0] leg_en,
    output logic                steady_done
);
    localparam int RAW_W = $clog2(INTERVAL + 1);
    localparam int CW    = (RAW_W < 5) ? 5 : RAW_W;
    localparam logic [NUM_LEGS-1:0] ONE_LEFT = {1'b1, {(NUM_LEGS-1){1'b0}}};

    xob_state_e state, state_nx;
    logic tick, run, step, kill, last_leg;

    assign last_leg = (leg_en == ONE_LEFT);

    xob_interval_timer #(.INTERVAL(INTERVAL), .CW(CW)) u_timer (
        .clk   (clk_osc),
        .rst_n (por_n),
        .run   (run),
        .tick  (tick)
    );

    xob_leg_bank #(.NUM_LEGS(NUM_LEGS)) u_legs (
        .clk   (clk_osc),
        .rst_n (por_n),
        .step  (step),
        .kill  (kill),
        .en    (leg_en)
    );

    always_ff @(posedge clk_osc or negedge por_n) begin
        if (!por_n) begin
            state <= ST_BOOST;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOST: begin
                if (force_lp)      state_nx = ST_STEADY;
                else if (tick)     state_nx = last_leg ? ST_STEADY : ST_TAPER;
            end
            ST_TAPER: begin
                if (force_lp)              state_nx = ST_STEADY;
                else if (tick && last_leg) state_nx = ST_STEADY;
            end
            ST_STEADY: state_nx = ST_STEADY;
            default:   state_nx = ST_STEADY;
        endcase
    end

    always_comb begin
        run         = 1'b0;
        step        = 1'b0;
        kill        = 1'b0;
        steady_done = 1'b0;
        unique case (state)
            ST_BOOST, ST_TAPER: begin
                run  = 1'b1;
                step = tick;
                kill = force_lp;
            end
            ST_STEADY: steady_done = 1'b1;
            default:   steady_done = 1'b1;
        endcase
    end

    // R5: without the override at most one leg drops per edge
    assert_one_step_R5: assert property (@(posedge clk_osc) disable iff (!por_n)
        !force_lp |=> ($countones(leg_en) + 1 >= $countones($past(leg_en))));

    // R6: the top leg falls only together with done
    assert_done_with_last_R6: assert property (@(posedge clk_osc) disable iff (!por_n)
        $fell(leg_en[NUM_LEGS-1]) |-> steady_done);

    // R7: done is sticky and means no drive left
    assert_done_sticky_R7: assert property (@(posedge clk_osc) disable iff (!por_n)
        steady_done |=> (steady_done && leg_en == '0));

    // R8: override empties the bank on the sampling edge
    assert_force_R8: assert property (@(posedge clk_osc) disable iff (!por_n)
        (force_lp && !steady_done) |=> (steady_done && leg_en == '0));
endmodule

// File: tb/sim_xo_boost_seq.sv
module sim_xo_boost_seq;
    localparam int IV = 28;

    typedef struct {
        int         k;
        logic [4:0] en;
        logic       done;
    } exp_t;

    logic       clk_osc = 1'b0;
    logic       por_n   = 1'b0;
    logic       force_lp = 1'b0;
    logic [4:0] leg_en;
    logic       steady_done;

    int   checks = 0;
    int   fails  = 0;
    int   edge_cnt = 0;
    int   cur_force = 0;
    logic [4:0] prev_en = 5'b11111;
    exp_t q[$];

    xo_boost_seq u0 (
        .clk_osc     (clk_osc),
        .por_n       (por_n),
        .force_lp    (force_lp),
        .leg_en      (leg_en),
        .steady_done (steady_done)
    );

    always #10 clk_osc = ~clk_osc;

    always @(posedge clk_osc) begin
        if (!por_n) edge_cnt = 0;
        else        edge_cnt = edge_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Monitor: pops expectations as edges occur
    always @(negedge clk_osc) begin
        if (por_n && q.size() > 0 && q[0].k == edge_cnt) begin
            exp_t e;
            string tag;
            e = q.pop_front();
            if (cur_force > 0 && e.k >= cur_force) tag = "R8";
            else if (e.k < IV)                     tag = "R2";
            else if (e.k >= 5*IV)                  tag = "R7";
            else                                   tag = "R3";
            check(leg_en === e.en, tag, $sformatf("leg_en edge %0d (R4 order)", e.k),
                  leg_en, e.en);
            check(steady_done === e.done, "R6", $sformatf("done edge %0d", e.k),
                  {4'b0, steady_done}, {4'b0, e.done});
            if (!(cur_force > 0 && e.k >= cur_force))
                check($countones(prev_en) - $countones(leg_en) <= 1, "R5",
                      "single leg per edge", leg_en, prev_en);
            prev_en = leg_en;
        end
    end

    function automatic void model(input int k, input int f,
                                  output logic [4:0] e, output logic d);
        int steps;
        steps = k / IV;
        if (steps > 5) steps = 5;
        if (f > 0 && k >= f) steps = 5;
        e = 5'b11111 << steps;
        d = (steps == 5);
    endfunction

    // Driver: reset, push expectations, then step through edges
    task automatic run_seq(input int n_edges, input int force_at);
        @(negedge clk_osc);
        #3 por_n = 1'b0;
        #1 check(leg_en === 5'b11111 && steady_done === 1'b0, "R10",
                 "async reset restores legs", leg_en, 5'b11111);
        repeat (2) @(negedge clk_osc);
        check(leg_en === 5'b11111 && steady_done === 1'b0, "R1",
              "reset state", leg_en, 5'b11111);
        cur_force = force_at;
        prev_en = 5'b11111;
        for (int k = 1; k <= n_edges; k++) begin
            exp_t e;
            e.k = k;
            model(k, force_at, e.en, e.done);
            q.push_back(e);
        end
        #5 por_n = 1'b1;
        for (int k = 1; k <= n_edges; k++) begin
            force_lp = (k == force_at) || (force_at > 5*IV && k >= force_at);
            @(negedge clk_osc);
        end
        force_lp = 1'b0;
        #1;
        check(q.size() == 0, "R2", "all expectations consumed",
              5'(q.size()), 5'd0);
    endtask

    initial begin
        // R9: override held through reset does nothing
        force_lp = 1'b1;
        repeat (3) @(negedge clk_osc);
        check(leg_en === 5'b11111 && steady_done === 1'b0, "R9",
              "force during reset", leg_en, 5'b11111);
        force_lp = 1'b0;

        run_seq(5*IV + 20, 0);    // full taper, R2 R3 R4 R6 R7
        run_seq(2*IV + 5, 0);     // aborted mid-taper, reset follows (R10)
        run_seq(IV + 2, 0);       // restart from zero after mid reset (R10)
        run_seq(10, 1);           // override on first edge (R8)
        run_seq(3*IV + 10, 2*IV + 7); // override mid-taper (R8)
        run_seq(5*IV + 12, 5*IV + 4); // override after done: no effect (R9)

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule